// File: doc/BRIEF.md
# Serial Latched Configuration Interface

This block accepts 8-bit configuration words on a three-wire serial link (data, shift clock, strobe) and spreads them over four internal registers: a monitor/mode register, two stepper registers and a register shared by the channel-5/6 PWM bridges and a third stepper. Every serial input is sampled in a fast system-clock domain through synchronizers. The two low bits of each word pick the register, so one link and one strobe reach all of them.

The applied fields do not all change at the same moment. Monitor, PWM, reference and hold fields change as soon as the strobe is seen. A stepper's counter-reset and output-enable fields wait for that stepper's next step-clock rise. Its direction and drive-mode fields wait for a step-clock fall followed by a rise. Until then the written values sit in shadow registers, so a coil sequence never sees a direction or mode change in the middle of a step.

Top module: `cfg_serial_top`

## Requirements
- R1: Bits enter least significant first. Each rising edge of `ser_clk` shifts in `ser_dat`, and a rising edge of `ser_stb` latches the last eight bits as word bits D7..D0, the first bit received being D0 and the eighth D7.
- R2: Word bits D1:D0 pick the target: 0 for the monitor/mode register, 1 for stepper 1, 2 for stepper 2, 3 for the channel-5/6 register, which also serves stepper 3. A word changes only the register it addresses.
- R3: A monitor word sets `mon_sel` from D3:D2, `mon_qtr[2:0]` from D6:D4 (D4 for stepper 1) and `ch56_micro` from D7. All of them change at the latch.
- R4: A stepper-1 or stepper-2 word carries direction in D2, drive mode in D4:D3 (D3 is `stp_ms` bit 0 of that stepper), hold in D5, active-low counter reset in D6 and output enable in D7.
- R5: A channel-5/6 word sets `pwm_ctl` from D5:D2 and `pwm_vref` from D7:D6 at the latch. For stepper 3 the same word carries direction in D2, hold in D3, active-low reset in D4 and output enable in D5. The stepper-3 drive mode is fixed at 2'b10.
- R6: Hold fields take effect at the latch without any step-clock edge.
- R7: Reset and output-enable fields take effect at the first rising edge of the target stepper's `step_clk` after the latch, and not earlier.
- R8: Direction and drive mode take effect only at the first `step_clk` rise that follows a `step_clk` fall seen after the latch. A rise with no fall before it leaves them unchanged.
- R9: A strobe after fewer or more than eight shift clocks latches the last eight bits received. Bits are kept across strobes.
- R10: After reset every applied field reads 0: counter resets asserted, outputs disabled. The exception is the stepper-3 drive mode, which reads 2'b10.
- R11: A second write to a stepper before its pending fields apply replaces the shadow values and restarts both waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ser_clk | input | 1 | serial shift clock |
| ser_dat | input | 1 | serial data |
| ser_stb | input | 1 | serial latch strobe |
| step_clk | input | 3 | step clock per stepper, bit 0 = stepper 1 |
| mon_sel | output | 2 | monitor source selection |
| mon_qtr | output | 3 | per-stepper monitor mode |
| ch56_micro | output | 1 | channel 5/6 microstep (1) or PWM (0) |
| pwm_ctl | output | 4 | channel-5/6 PWM control bits D5:D2 |
| pwm_vref | output | 2 | current reference selection |
| stp_dir | output | 3 | applied direction per stepper |
| stp_ms | output | 6 | applied drive mode, 2 bits per stepper |
| stp_hold | output | 3 | applied hold per stepper |
| stp_rst_n | output | 3 | applied active-low counter reset |
| stp_oe | output | 3 | applied output enable |

## Verification
The bench targets the three apply moments. It checks that reset and enable stay put until a step rise and that direction and mode ignore a rise with no fall before it. A design that applied everything at the strobe, or that counted a fall seen before the latch, would show the new value one check too early. It also rewrites a stepper while fields are pending, sends short and long frames, and writes each register in turn. These catch a design that keeps stale shadow values, clears its shift register at the strobe, or decodes the wrong address bits.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int WORD_W = 8;
  localparam int ADDR_W = 2;
  localparam int N_STP  = 3;
  localparam int MS_W   = 2;
  localparam int PWM_W  = 4;
  localparam int VREF_W = 2;
  localparam int MSEL_W = 2;
  localparam logic [MS_W-1:0] FIXED_MS = 2'b10;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MON  = 2'd0,
    SEL_STP1 = 2'd1,
    SEL_STP2 = 2'd2,
    SEL_CH56 = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    DM_IDLE   = 2'd0,
    DM_ARMED  = 2'd1,
    DM_FALLEN = 2'd2
  } dm_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_shift_rx.sv
module cfg_shift_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         dat_s,
  input  logic         stb_s,
  output logic         ld,
  output logic [W-1:0] word
);
  logic         sclk_q, stb_q;
  logic [W-1:0] sh_q, sh_n;
  logic         sclk_rise;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_q;
    sh_n      = sh_q;
    if (sclk_rise) sh_n = {dat_s, sh_q[W-1:1]};
  end

  assign ld   = stb_s & ~stb_q;
  assign word = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      stb_q  <= 1'b0;
      sh_q   <= '0;
    end else begin
      sclk_q <= sclk_s;
      stb_q  <= stb_s;
      sh_q   <= sh_n;
    end
  end
endmodule

// File: rtl/cfg_stage.sv
module cfg_stage
  import cfg_pkg::*;
#(
  parameter logic [MS_W-1:0] MS_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_s,
  input  logic            ld,
  input  logic            d_dir,
  input  logic [MS_W-1:0] d_ms,
  input  logic            d_rst_n,
  input  logic            d_oe,
  output logic            o_dir,
  output logic [MS_W-1:0] o_ms,
  output logic            o_rst_n,
  output logic            o_oe
);
  logic            step_q;
  dm_state_e       st_q, st_n;
  logic            sv_dir_q, sv_dir_n;
  logic [MS_W-1:0] sv_ms_q, sv_ms_n;
  logic            sv_rst_q, sv_rst_n;
  logic            sv_oe_q, sv_oe_n;
  logic            pend_q, pend_n;
  logic            a_dir_q, a_dir_n;
  logic [MS_W-1:0] a_ms_q, a_ms_n;
  logic            a_rst_q, a_rst_n;
  logic            a_oe_q, a_oe_n;
  logic            rise, fall;

  always_comb begin
    rise     = step_s & ~step_q;
    fall     = ~step_s & step_q;
    st_n     = st_q;
    sv_dir_n = sv_dir_q;
    sv_ms_n  = sv_ms_q;
    sv_rst_n = sv_rst_q;
    sv_oe_n  = sv_oe_q;
    pend_n   = pend_q;
    a_dir_n  = a_dir_q;
    a_ms_n   = a_ms_q;
    a_rst_n  = a_rst_q;
    a_oe_n   = a_oe_q;
    if (ld) begin
      // edges in the latch cycle do not count toward either wait
      sv_dir_n = d_dir;
      sv_ms_n  = d_ms;
      sv_rst_n = d_rst_n;
      sv_oe_n  = d_oe;
      pend_n   = 1'b1;
      st_n     = DM_ARMED;
    end else begin
      if (pend_q && rise) begin
        a_rst_n = sv_rst_q;
        a_oe_n  = sv_oe_q;
        pend_n  = 1'b0;
      end
      case (st_q)
        DM_ARMED:  if (fall) st_n = DM_FALLEN;
        DM_FALLEN: if (rise) begin
          a_dir_n = sv_dir_q;
          a_ms_n  = sv_ms_q;
          st_n    = DM_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= 1'b0;
      st_q     <= DM_IDLE;
      sv_dir_q <= 1'b0;
      sv_ms_q  <= MS_RST;
      sv_rst_q <= 1'b0;
      sv_oe_q  <= 1'b0;
      pend_q   <= 1'b0;
      a_dir_q  <= 1'b0;
      a_ms_q   <= MS_RST;
      a_rst_q  <= 1'b0;
      a_oe_q   <= 1'b0;
    end else begin
      step_q   <= step_s;
      st_q     <= st_n;
      sv_dir_q <= sv_dir_n;
      sv_ms_q  <= sv_ms_n;
      sv_rst_q <= sv_rst_n;
      sv_oe_q  <= sv_oe_n;
      pend_q   <= pend_n;
      a_dir_q  <= a_dir_n;
      a_ms_q   <= a_ms_n;
      a_rst_q  <= a_rst_n;
      a_oe_q   <= a_oe_n;
    end
  end

  assign o_dir   = a_dir_q;
  assign o_ms    = a_ms_q;
  assign o_rst_n = a_rst_q;
  assign o_oe    = a_oe_q;
endmodule

// File: rtl/cfg_serial_top.sv
module cfg_serial_top
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk,
  input  logic                   ser_dat,
  input  logic                   ser_stb,
  input  logic [N_STP-1:0]       step_clk,
  output logic [MSEL_W-1:0]      mon_sel,
  output logic [N_STP-1:0]       mon_qtr,
  output logic                   ch56_micro,
  output logic [PWM_W-1:0]       pwm_ctl,
  output logic [VREF_W-1:0]      pwm_vref,
  output logic [N_STP-1:0]       stp_dir,
  output logic [MS_W*N_STP-1:0]  stp_ms,
  output logic [N_STP-1:0]       stp_hold,
  output logic [N_STP-1:0]       stp_rst_n,
  output logic [N_STP-1:0]       stp_oe
);
  localparam int SYNC_W = 3 + N_STP;

  logic [SYNC_W-1:0] sync_q;
  logic              sclk_s, dat_s, stb_s;
  logic [N_STP-1:0]  step_s;
  logic              rx_ld;
  logic [WORD_W-1:0] rx_word;
  reg_sel_e          sel;

  cfg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({step_clk, ser_stb, ser_dat, ser_clk}),
    .q(sync_q)
  );
  assign {step_s, stb_s, dat_s, sclk_s} = sync_q;

  cfg_shift_rx #(.W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .dat_s(dat_s), .stb_s(stb_s),
    .ld(rx_ld), .word(rx_word)
  );

  assign sel = reg_sel_e'(rx_word[ADDR_W-1:0]);

  // immediate registers
  logic [MSEL_W-1:0] msel_q, msel_n;
  logic [N_STP-1:0]  mqtr_q, mqtr_n;
  logic              micro_q, micro_n;
  logic [PWM_W-1:0]  pwm_q, pwm_n;
  logic [VREF_W-1:0] vref_q, vref_n;
  logic [N_STP-1:0]  hold_q, hold_n;

  logic [N_STP-1:0]      stp_ld, c_dir, c_rst, c_oe, c_hold;
  logic [MS_W-1:0]       c_ms [N_STP];

  genvar gi;
  generate
    for (gi = 0; gi < N_STP; gi++) begin : g_stp
      if (gi < N_STP - 1) begin : g_full
        assign stp_ld[gi] = rx_ld && (rx_word[ADDR_W-1:0] == ADDR_W'(gi + 1));
        assign c_dir[gi]  = rx_word[2];
        assign c_ms[gi]   = rx_word[4:3];
        assign c_hold[gi] = rx_word[5];
        assign c_rst[gi]  = rx_word[6];
        assign c_oe[gi]   = rx_word[7];
      end else begin : g_fixed
        assign stp_ld[gi] = rx_ld && (sel == SEL_CH56);
        assign c_dir[gi]  = rx_word[2];
        assign c_ms[gi]   = FIXED_MS;
        assign c_hold[gi] = rx_word[3];
        assign c_rst[gi]  = rx_word[4];
        assign c_oe[gi]   = rx_word[5];
      end

      cfg_stage #(.MS_RST((gi < N_STP - 1) ? '0 : FIXED_MS)) u_stage (
        .clk(clk), .rst_n(rst_n), .step_s(step_s[gi]), .ld(stp_ld[gi]),
        .d_dir(c_dir[gi]), .d_ms(c_ms[gi]), .d_rst_n(c_rst[gi]), .d_oe(c_oe[gi]),
        .o_dir(stp_dir[gi]), .o_ms(stp_ms[gi*MS_W +: MS_W]),
        .o_rst_n(stp_rst_n[gi]), .o_oe(stp_oe[gi])
      );
    end
  endgenerate

  always_comb begin
    msel_n  = msel_q;
    mqtr_n  = mqtr_q;
    micro_n = micro_q;
    pwm_n   = pwm_q;
    vref_n  = vref_q;
    hold_n  = hold_q;
    if (rx_ld && sel == SEL_MON) begin
      msel_n  = rx_word[3:2];
      mqtr_n  = rx_word[6:4];
      micro_n = rx_word[7];
    end
    if (rx_ld && sel == SEL_CH56) begin
      pwm_n  = rx_word[5:2];
      vref_n = rx_word[7:6];
    end
    for (int k = 0; k < N_STP; k++) begin
      if (stp_ld[k]) hold_n[k] = c_hold[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msel_q  <= '0;
      mqtr_q  <= '0;
      micro_q <= 1'b0;
      pwm_q   <= '0;
      vref_q  <= '0;
      hold_q  <= '0;
    end else begin
      msel_q  <= msel_n;
      mqtr_q  <= mqtr_n;
      micro_q <= micro_n;
      pwm_q   <= pwm_n;
      vref_q  <= vref_n;
      hold_q  <= hold_n;
    end
  end

  assign mon_sel    = msel_q;
  assign mon_qtr    = mqtr_q;
  assign ch56_micro = micro_q;
  assign pwm_ctl    = pwm_q;
  assign pwm_vref   = vref_q;
  assign stp_hold   = hold_q;
endmodule

// File: rtl/cfg_serial_chk.sv
module cfg_serial_chk
  import cfg_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ld,
  input logic [N_STP-1:0]      step_s,
  input logic [MSEL_W-1:0]     mon_sel,
  input logic [PWM_W-1:0]      pwm_ctl,
  input logic [N_STP-1:0]      stp_dir,
  input logic [MS_W*N_STP-1:0] stp_ms,
  input logic [N_STP-1:0]      stp_hold,
  input logic [N_STP-1:0]      stp_rst_n,
  input logic [N_STP-1:0]      stp_oe
);
  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (stp_oe == '0 && stp_rst_n == '0 && stp_dir == '0);
    end
  end

  // R3
  mon_at_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mon_sel) |-> $past(ld));

  // R5
  pwm_at_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwm_ctl) |-> $past(ld));

  // R5
  fixed_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stp_ms[MS_W*N_STP-1 -: MS_W] == FIXED_MS);

  genvar gi;
  generate
    for (gi = 0; gi < N_STP; gi++) begin : g_chk
      // R6
      hold_at_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stp_hold[gi]) |-> $past(ld));
      // R7
      oe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stp_oe[gi]) |-> ($past(step_s[gi]) && !$past(step_s[gi], 2)));
      // R7
      rst_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stp_rst_n[gi]) |-> ($past(step_s[gi]) && !$past(step_s[gi], 2)));
      // R8
      dir_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stp_dir[gi]) |-> ($past(step_s[gi]) && !$past(step_s[gi], 2)));
    end
  endgenerate
endmodule

bind cfg_serial_top cfg_serial_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld(rx_ld), .step_s(step_s),
  .mon_sel(mon_sel), .pwm_ctl(pwm_ctl), .stp_dir(stp_dir), .stp_ms(stp_ms),
  .stp_hold(stp_hold), .stp_rst_n(stp_rst_n), .stp_oe(stp_oe)
);

// File: tb/tb_cfg_serial_top.sv
module tb_cfg_serial_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, ser_clk, ser_dat, ser_stb;
  logic [2:0] step_clk;
  logic [1:0] mon_sel;
  logic [2:0] mon_qtr;
  logic       ch56_micro;
  logic [3:0] pwm_ctl;
  logic [1:0] pwm_vref;
  logic [2:0] stp_dir, stp_hold, stp_rst_n, stp_oe;
  logic [5:0] stp_ms;

  cfg_serial_top dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb),
    .step_clk(step_clk), .mon_sel(mon_sel), .mon_qtr(mon_qtr), .ch56_micro(ch56_micro),
    .pwm_ctl(pwm_ctl), .pwm_vref(pwm_vref), .stp_dir(stp_dir), .stp_ms(stp_ms),
    .stp_hold(stp_hold), .stp_rst_n(stp_rst_n), .stp_oe(stp_oe)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected applied state
  logic [1:0] e_msel;
  logic [2:0] e_mqtr;
  logic       e_micro;
  logic [3:0] e_pwm;
  logic [1:0] e_vref;
  logic [2:0] e_dir, e_hold, e_rst, e_oe;
  logic [5:0] e_ms;
  // pending state model
  logic [2:0] p2, p2_rst, p2_oe, p1_dir;
  int         p1_st [3];
  logic [5:0] p1_ms;
  logic [7:0] tb_sh;

  logic [29:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [29:0] pack_exp();
    return {e_msel, e_mqtr, e_micro, e_pwm, e_vref, e_dir, e_ms, e_hold, e_rst, e_oe};
  endfunction

  function automatic logic [29:0] pack_act();
    return {mon_sel, mon_qtr, ch56_micro, pwm_ctl, pwm_vref, stp_dir, stp_ms,
            stp_hold, stp_rst_n, stp_oe};
  endfunction

  task automatic chk(input string tag);
    exp_q.push_back(pack_exp());
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor: compares away from the active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [29:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (pack_act() !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, pack_act(), e);
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_word(input logic [7:0] w);
    int idx;
    case (w[1:0])
      2'd0: begin
        e_msel = w[3:2]; e_mqtr = w[6:4]; e_micro = w[7];
      end
      2'd1, 2'd2: begin
        idx = int'(w[1:0]) - 1;
        e_hold[idx] = w[5];
        p2[idx] = 1'b1; p2_rst[idx] = w[6]; p2_oe[idx] = w[7];
        p1_st[idx] = 1; p1_dir[idx] = w[2]; p1_ms[2*idx +: 2] = w[4:3];
      end
      default: begin
        e_pwm = w[5:2]; e_vref = w[7:6]; e_hold[2] = w[3];
        p2[2] = 1'b1; p2_rst[2] = w[4]; p2_oe[2] = w[5];
        p1_st[2] = 1; p1_dir[2] = w[2]; p1_ms[5:4] = 2'b10;
      end
    endcase
  endtask

  task automatic shift_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      ser_dat = v[i];
      wait_clk(15);
      ser_clk = 1'b1;
      tb_sh = {v[i], tb_sh[7:1]};
      wait_clk(15);
      ser_clk = 1'b0;
    end
  endtask

  task automatic strobe();
    wait_clk(15);
    ser_stb = 1'b1;
    apply_word(tb_sh);
    wait_clk(15);
    ser_stb = 1'b0;
    wait_clk(15);
  endtask

  task automatic write(input logic [7:0] w);
    shift_bits({8'h00, w}, 8);
    strobe();
  endtask

  task automatic step(input int i, input logic v);
    step_clk[i] = v;
    if (v) begin
      if (p2[i]) begin e_rst[i] = p2_rst[i]; e_oe[i] = p2_oe[i]; p2[i] = 1'b0; end
      if (p1_st[i] == 2) begin
        e_dir[i] = p1_dir[i]; e_ms[2*i +: 2] = p1_ms[2*i +: 2]; p1_st[i] = 0;
      end
    end else if (p1_st[i] == 1) begin
      p1_st[i] = 2;
    end
    wait_clk(12);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_stb = 1'b0; step_clk = '0;
    e_msel = '0; e_mqtr = '0; e_micro = 1'b0; e_pwm = '0; e_vref = '0;
    e_dir = '0; e_hold = '0; e_rst = '0; e_oe = '0; e_ms = 6'b10_00_00;
    p2 = '0; p2_rst = '0; p2_oe = '0; p1_dir = '0; p1_ms = 6'b10_00_00;
    for (int k = 0; k < 3; k++) p1_st[k] = 0;
    tb_sh = '0;
    wait_clk(5);
    chk("R10 reset state");
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(5);

    // R1 R2 R3: asymmetric monitor word, applied at the latch
    write(8'b1_011_10_00);
    chk("R1 R3 monitor word at latch");

    // R4 R7 R8: stepper 1 word, pending until step clock edges
    write(8'b1_1_0_1_1_1_01);
    chk("R7 R8 stepper fields wait for step clock");
    step(0, 1'b1);
    chk("R7 reset and enable on first rise, R8 mode held");
    step(0, 1'b0);
    chk("R8 fall alone changes nothing");
    step(0, 1'b1);
    chk("R4 R8 direction and mode on rise after fall");

    // R6: hold applies with no step edge
    write(8'b1_1_1_1_1_1_01);
    chk("R6 hold at latch");

    // R2: stepper 2 write leaves stepper 1 and monitor alone
    write(8'b1_1_0_0_1_1_10);
    chk("R2 stepper 2 only pending");
    step(1, 1'b1);
    step(1, 1'b0);
    step(1, 1'b1);
    chk("R2 R4 stepper 2 applied, others unchanged");

    // R5: channel 5/6 word
    write(8'b10_1_1_0_1_11);
    chk("R5 pwm and reference at latch");
    step(2, 1'b1);
    chk("R5 R7 stepper 3 reset and enable");
    step(2, 1'b0);
    step(2, 1'b1);
    chk("R5 R8 stepper 3 direction, fixed mode");

    // R11: rewrite before trigger replaces values and restarts the wait
    step(1, 1'b0);
    write(8'b0_1_0_1_0_1_10);
    step(1, 1'b1);
    write(8'b1_0_0_0_1_0_10);
    chk("R11 second write pending");
    step(1, 1'b0);
    step(1, 1'b1);
    chk("R11 latest values applied");

    // R9: short frame keeps old bits, long frame keeps last eight
    write(8'b1_100_10_00);
    chk("R3 monitor rewrite");
    shift_bits(16'h0006, 4);
    strobe();
    chk("R9 short frame");
    shift_bits(16'b10_0101_0100_11, 10);
    strobe();
    chk("R9 long frame");

    // R2: monitor write does not touch steppers
    write(8'b0_000_01_00);
    chk("R2 monitor write leaves steppers");

    wait_clk(10);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule